// File: doc/BRIEF.md
# Loss-of-Signal Detector

This block watches a recovered receive bit stream, one bit per clock enable, and raises a loss-of-signal status once the line has delivered a programmable number T of consecutive zero bits. Once the status is up, the block looks for the line coming back. It opens observation windows of T valid bit periods and drops the status as soon as M one bits have arrived inside the current window. A window that closes with fewer than M ones is discarded, and counting starts over in a fresh window.

A simulation control forces the status high so that alarm handling further up can be exercised. The real detection keeps running underneath. When simulation is released, the status stays high only if a real loss condition is present. Every rising edge of the status produces a one-clock interrupt pulse. Configuration (T and M) arrives on plain input ports. T is meant to lie in 17..4095 and M in 1..T.

Top module: `los_detector`

## Requirements
- R1: While `rstN` is low (active low), `losStatus` and `losIrq` are 0, and all counters are cleared.
- R2: With `simEn` low and the status clear, `losStatus` goes to 1 at the clock edge that samples the T-th consecutive valid zero (`bitIn`=0, `bitValid`=1). Here T is `winLen` in 17..4095. A valid one (`bitIn`=1) before that point restarts the run, so T-1 zeros followed by a one do not set the status.
- R3: Cycles with `bitValid`=0 neither advance nor restart any count, whatever the value on `bitIn`.
- R4: While a real alarm is held, `losStatus` goes to 0 at the clock edge that samples the valid bit bringing the number of ones in the current recovery window to M. M is `onesNeed` in 1..T. The status stays 1 while fewer than M ones have arrived.
- R5: A recovery window lasts T valid bits. When it ends with fewer than M ones, a new window starts with its ones count at zero, and ones from the old window do not count toward recovery.
- R6: `losIrq` is 1 for exactly the one clock cycle in which `losStatus` has just changed from 0 to 1, and it is 0 at all other times.
- R7: With `simEn`=1 sampled at an edge, `losStatus` is 1 after that edge. After `simEn` returns to 0, the status clears at the next edge if no real alarm is held, and stays 1 if a real alarm is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Received data bit, 1 = one |
| winLen | input | CNT_W | Zero-run length and recovery window length T |
| onesNeed | input | CNT_W | Ones needed inside one window to recover, M |
| simEn | input | 1 | Alarm simulation, forces the status high |
| losStatus | output | 1 | Loss-of-signal status |
| losIrq | output | 1 | One-cycle pulse on the status rising edge |

## Verification
The bench sweeps every pairing of T in 17..24 and M in 1..4. For each pair it first sends a zero run one bit short of T and broken by a one, which separates a true run count from a total zero count. It then sends a full run with idle cycles carrying ones placed between the bits, which shows that unqualified cycles are inert. Recovery is tried with a window that ends holding M-1 ones, followed by M-1 early ones in the next window. This pattern only stays alarmed if the window restart discards the old count, and the M-th one then pins the exact clearing edge. Separate sequences with simulation toggled show the difference between a release with a real alarm held and a release without one, and check that the interrupt fires only on genuine rising edges.

// File: rtl/los_pkg.sv
package los_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic runZero;  // count the consecutive-zero run
    logic runWin;   // count the recovery window and its ones
    logic clrAll;   // clear every counter this cycle
  } los_strobe_t;

  // Qualified compare results from datapath to control
  typedef struct packed {
    logic zeroHit;  // this valid zero completes the run
    logic onesHit;  // this valid bit reaches the ones target
    logic winEnd;   // this valid bit closes the window
  } los_flag_t;

endpackage

// File: rtl/los_datapath.sv
module los_datapath
  import los_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic [CNT_W-1:0] winLen,
  input  logic [CNT_W-1:0] onesNeed,
  input  los_strobe_t      strb,
  output los_flag_t        flg
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] zeroRun;
  logic [CNT_W-1:0] winCnt;
  logic [CNT_W-1:0] onesCnt;
  logic [SUM_W-1:0] zeroNext;
  logic [SUM_W-1:0] winNext;
  logic [SUM_W-1:0] onesNext;
  logic [SUM_W-1:0] winLenX;
  logic [SUM_W-1:0] onesNeedX;

  assign winLenX   = {1'b0, winLen};
  assign onesNeedX = {1'b0, onesNeed};
  assign zeroNext  = {1'b0, zeroRun} + SUM_W'(1);
  assign winNext   = {1'b0, winCnt} + SUM_W'(1);
  assign onesNext  = {1'b0, onesCnt} + SUM_W'(bitIn);

  // Compares use >= so a shortened window mid-count still terminates
  always_comb begin
    flg.zeroHit = bitValid && !bitIn && (zeroNext >= winLenX);
    flg.winEnd  = bitValid && (winNext >= winLenX);
    flg.onesHit = bitValid && (onesNext >= onesNeedX);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) begin
      zeroRun <= '0;
      winCnt  <= '0;
      onesCnt <= '0;
    end else if (bitValid) begin
      if (strb.runZero) begin
        zeroRun <= bitIn ? '0 : zeroNext[CNT_W-1:0];
      end
      if (strb.runWin) begin
        if (flg.winEnd) begin
          winCnt  <= '0;
          onesCnt <= '0;
        end else begin
          winCnt  <= winNext[CNT_W-1:0];
          onesCnt <= onesNext[CNT_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/los_control.sv
module los_control
  import los_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        simEn,
  input  los_flag_t   flg,
  output los_strobe_t strb,
  output logic        losStatus,
  output logic        losIrq
);

  logic realLos;
  logic realNext;
  logic statusNext;

  always_comb begin
    realNext     = realLos ? !flg.onesHit : flg.zeroHit;
    strb.runZero = !realLos;
    strb.runWin  = realLos;
    strb.clrAll  = realLos ? flg.onesHit : flg.zeroHit;
    statusNext   = realNext || simEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      realLos   <= 1'b0;
      losStatus <= 1'b0;
      losIrq    <= 1'b0;
    end else begin
      realLos   <= realNext;
      losStatus <= statusNext;
      losIrq    <= statusNext && !losStatus;
    end
  end

endmodule

// File: rtl/los_detector.sv
module los_detector
  import los_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic [CNT_W-1:0] winLen,
  input  logic [CNT_W-1:0] onesNeed,
  input  logic             simEn,
  output logic             losStatus,
  output logic             losIrq
);

  los_strobe_t strb;
  los_flag_t   flg;

  los_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .winLen   (winLen),
    .onesNeed (onesNeed),
    .strb     (strb),
    .flg      (flg)
  );

  los_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .simEn     (simEn),
    .flg       (flg),
    .strb      (strb),
    .losStatus (losStatus),
    .losIrq    (losIrq)
  );

endmodule

// File: rtl/los_checker.sv
module los_checker (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic bitIn,
  input logic simEn,
  input logic losStatus,
  input logic losIrq
);

  // R6: a pulse only accompanies a freshly set status
  p_irq_has_status_r6: assert property (@(posedge clk) disable iff (!rstN)
    losIrq |-> (losStatus && !$past(losStatus)));

  // R6: every rise of the status is announced
  p_rise_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(losStatus) |-> losIrq);

  // R7: simulation forces the status after the edge
  p_sim_force_r7: assert property (@(posedge clk) disable iff (!rstN)
    simEn |=> losStatus);

  // R3: no qualified bit and no simulation means no status change
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !simEn && !$past(simEn)) |=> $stable(losStatus));

  // R2: a rise needs simulation or a valid zero
  p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(losStatus) |-> ($past(simEn) || ($past(bitValid) && !$past(bitIn))));

  // R7: the status never drops while simulation is applied
  p_fall_no_sim_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(losStatus) |-> !$past(simEn));

endmodule

bind los_detector los_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitValid  (bitValid),
  .bitIn     (bitIn),
  .simEn     (simEn),
  .losStatus (losStatus),
  .losIrq    (losIrq)
);

// File: tb/sim_los_detector.sv
`timescale 1ns/1ps
module sim_los_detector;

  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rstN;
  logic             bitValid;
  logic             bitIn;
  logic [CNT_W-1:0] winLen;
  logic [CNT_W-1:0] onesNeed;
  logic             simEn;
  logic             losStatus;
  logic             losIrq;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  los_detector #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .winLen(winLen), .onesNeed(onesNeed), .simEn(simEn),
    .losStatus(losStatus), .losIrq(losIrq)
  );

  // Drive at a falling edge; return at the next falling edge with the result
  task automatic step(input logic v, input logic b);
    bitValid = v;
    bitIn    = b;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nErr++;
      nChk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; bitValid = 1'b0; bitIn = 1'b0; simEn = 1'b0;
    winLen = 12'd17; onesNeed = 12'd1;
    @(negedge clk);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk("R1 reset status", losStatus, 1'b0);
    chk("R1 reset irq", losIrq, 1'b0);
    rstN = 1'b1;

    for (int t = 17; t <= 24; t++) begin
      for (int m = 1; m <= 4; m++) begin
        winLen = CNT_W'(t);
        onesNeed = CNT_W'(m);
        doReset();
        // Run one short, stalls carry ones that must be ignored
        for (int i = 0; i < t - 1; i++) begin
          step(1'b1, 1'b0);
          chk("R2 short run", losStatus, 1'b0);
          step(1'b0, 1'b1);
          chk("R3 stall no restart", losStatus, 1'b0);
        end
        step(1'b1, 1'b1);
        chk("R2 one breaks run", losStatus, 1'b0);
        for (int i = 0; i < t - 1; i++) begin
          step(1'b1, 1'b0);
          chk("R2 run again", losStatus, 1'b0);
          step(1'b0, 1'b1);
        end
        step(1'b1, 1'b0);
        chk("R2 set at T-th zero", losStatus, 1'b1);
        chk("R6 irq on rise", losIrq, 1'b1);
        step(1'b0, 1'b1);
        chk("R6 irq single", losIrq, 1'b0);
        for (int i = 0; i < 4; i++) begin
          step(1'b0, 1'b1);
          chk("R3 stall ones ignored", losStatus, 1'b1);
        end
        // Window of T bits ending with M-1 ones
        for (int i = 0; i < t; i++) begin
          step(1'b1, (i >= t - m + 1) ? 1'b1 : 1'b0);
          chk("R4 held below M", losStatus, 1'b1);
        end
        // New window: M-1 ones must not clear
        for (int i = 0; i < m - 1; i++) begin
          step(1'b1, 1'b1);
          chk("R5 window restart", losStatus, 1'b1);
        end
        step(1'b1, 1'b1);
        chk("R4 clear at M-th one", losStatus, 1'b0);
        chk("R6 no irq on fall", losIrq, 1'b0);
      end
    end

    // Simulation without real alarm
    winLen = 12'd17; onesNeed = 12'd2;
    doReset();
    simEn = 1'b1;
    step(1'b0, 1'b0);
    chk("R7 sim forces", losStatus, 1'b1);
    chk("R6 irq on sim rise", losIrq, 1'b1);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1);
      chk("R7 sim holds", losStatus, 1'b1);
      chk("R6 no repeat irq", losIrq, 1'b0);
    end
    simEn = 1'b0;
    step(1'b0, 1'b0);
    chk("R7 release clears", losStatus, 1'b0);

    // Simulation with a real alarm underneath
    simEn = 1'b1;
    step(1'b0, 1'b0);
    chk("R7 sim forces again", losStatus, 1'b1);
    for (int i = 0; i < 17; i++) begin
      step(1'b1, 1'b0);
      chk("R6 no irq under sim", losIrq, 1'b0);
    end
    simEn = 1'b0;
    step(1'b0, 1'b0);
    chk("R7 release keeps real alarm", losStatus, 1'b1);
    chk("R6 no irq on release", losIrq, 1'b0);
    step(1'b1, 1'b1);
    chk("R4 one below M", losStatus, 1'b1);
    step(1'b1, 1'b1);
    chk("R4 clears after sim", losStatus, 1'b0);

    // Reset mid-alarm
    for (int i = 0; i < 17; i++) step(1'b1, 1'b0);
    chk("R2 set before reset", losStatus, 1'b1);
    rstN = 1'b0;
    step(1'b1, 1'b0);
    chk("R1 reset clears status", losStatus, 1'b0);
    chk("R1 reset irq low", losIrq, 1'b0);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0);
    chk("R1 counters cleared", losStatus, 1'b0);
    step(1'b1, 1'b0);
    chk("R2 set after reset", losStatus, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule